// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a byte-wide nonvolatile memory model. A host drives it with static-RAM style strobes: an active-low chip select, an active-low write strobe and an active-low output enable. Each qualified strobe loads one byte into a page holding buffer, and a per-byte mask records which bytes were loaded. The first byte of a load fixes the page. Later bytes must target that same page.

Loading has no explicit end command. It ends when no further byte is accepted within a configurable number of clock cycles. The controller then enters a timed programming phase and raises `busy` for a fixed number of cycles. During that phase it walks the buffer and copies only the masked bytes into a synchronous storage array. When programming finishes, the buffer and the mask are cleared.

The write side has no valid/ready handshake. The strobe protocol cannot be stalled, so `busy` is the only flow-control signal. While `busy` is high, strobes are dropped and the host must wait. The read port is plain: it takes an address and returns the stored byte one cycle later. All timing is given as clock-cycle parameters, so a bench can shorten the windows.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `busy` is low and every array location reads 0.
- R2: A byte is accepted only when `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together on at least MIN_LOW consecutive clock edges. A shorter overlap, or one with `oe_n` low, loads nothing.
- R3: The address is taken on the first clock edge of the joint-low interval. The data is taken on the last edge before either strobe rises, whichever strobe rises first.
- R4: The page is `addr[ADDR_W-1:7]` and the byte is `addr[6:0]`. The first accepted byte locks the page. A later byte with a different page is discarded and does not restart the load timer.
- R5: Each accepted byte restarts the load timer. After LOAD_TIMEOUT cycles without an accepted byte, programming starts and `busy` rises.
- R6: `busy` stays high for exactly PROG_CYCLES cycles per programming phase.
- R7: Only loaded bytes are written to the array and all other bytes keep their values. Bytes may be loaded in any order. A byte loaded twice stores its last value.
- R8: Strobes that arrive while `busy` is high are ignored. They load nothing and start no new load.
- R9: The mask is cleared when programming ends, so a later load programs only its own bytes.
- R10: `rd_data` shows the array byte at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; a low level inhibits writes |
| addr | input | ADDR_W | Write address (page and byte offset) |
| wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | High during the programming phase |

## Verification
The bench targets the following corner cases, and each one exposes a distinct failure:
- Strobe overlaps one cycle short of the qualification length, and strobes with `oe_n` low. A loose filter would program these bytes.
- A strobe whose address and data change while it is held. A controller that sampled at the wrong end would store the second address or the first data value.
- A byte from a foreign page sent just before the window expires. A controller that lets it restart the timer would start programming far too late.
- A strobe sent in the middle of programming, and a single-byte load that follows a multi-byte one. A stale mask, or acceptance during `busy`, would corrupt bytes that the full array readback compares against an arithmetic model.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PLC_IDLE = 2'd0,
    PLC_LOAD = 2'd1,
    PLC_PROG = 2'd2
  } plc_state_t;
endpackage

// File: rtl/plc_strobe_qual.sv
// Turns asynchronous-looking SRAM strobes (sampled on clk) into one-cycle
// byte events. Address is taken on the first joint-low edge, data on the last.
module plc_strobe_qual #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int MIN_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              stb,
  output logic [ADDR_W-1:0] stb_addr,
  output logic [DATA_W-1:0] stb_data
);
  localparam int RUN_W = $clog2(MIN_LOW + 1);

  logic             act;
  logic             act_q;
  logic [RUN_W-1:0] run;

  assign act = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      run      <= '0;
      stb      <= 1'b0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      act_q <= act;
      stb   <= !act && act_q && (run >= RUN_W'(MIN_LOW));
      if (act) begin
        stb_data <= wdata;
        if (!act_q) begin
          stb_addr <= addr;
          run      <= RUN_W'(1);
        end else if (run < RUN_W'(MIN_LOW)) begin
          run <= run + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/plc_page_buf.sv
// Page holding buffer: one register lane per byte plus its loaded flag.
module plc_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_OFS_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [PAGE_OFS_W-1:0]     widx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      clr,
  input  logic [PAGE_OFS_W-1:0]     ridx,
  output logic [DATA_W-1:0]         rdata,
  output logic [(1<<PAGE_OFS_W)-1:0] valid_mask
);
  localparam int PAGE_BYTES = 1 << PAGE_OFS_W;

  logic [DATA_W-1:0] lane [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic hit;
    assign hit = we && (widx == PAGE_OFS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane[g]       <= '0;
        valid_mask[g] <= 1'b0;
      end else if (clr) begin
        lane[g]       <= '0;
        valid_mask[g] <= 1'b0;
      end else if (hit) begin
        lane[g]       <= wdata;
        valid_mask[g] <= 1'b1;
      end
    end
  end

  assign rdata = lane[ridx];
endmodule

// File: rtl/plc_load_seq.sv
// Load / program sequencer: page lock, byte-load window, timed copy-out.
module plc_load_seq
  import plc_pkg::*;
#(
  parameter int PAGE_W       = 3,
  parameter int PAGE_OFS_W   = 7,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 15000,
  parameter int PROG_CYCLES  = 1000000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stb,
  input  logic [PAGE_W-1:0]            stb_page,
  input  logic [PAGE_OFS_W-1:0]        stb_ofs,
  input  logic [(1<<PAGE_OFS_W)-1:0]   valid_mask,
  input  logic [DATA_W-1:0]            buf_rdata,
  output logic                         buf_we,
  output logic [PAGE_OFS_W-1:0]        buf_widx,
  output logic                         buf_clr,
  output logic [PAGE_OFS_W-1:0]        buf_ridx,
  output logic                         ram_we,
  output logic [PAGE_W+PAGE_OFS_W-1:0] ram_waddr,
  output logic [DATA_W-1:0]            ram_wdata,
  output logic [PAGE_W-1:0]            locked_page,
  output logic                         loading,
  output logic                         busy
);
  localparam int PAGE_BYTES = 1 << PAGE_OFS_W;
  localparam int TMO_W      = $clog2(LOAD_TIMEOUT + 1);
  localparam int PRG_W      = $clog2(PROG_CYCLES + 1);

  plc_state_t       state;
  logic [TMO_W-1:0] tmr;
  logic [PRG_W-1:0] prg;
  logic             page_hit;
  logic             prg_last;
  logic             in_copy;

  assign page_hit = stb && (state == PLC_LOAD) && (stb_page == locked_page);
  assign prg_last = (prg == PRG_W'(PROG_CYCLES - 1));
  assign in_copy  = (state == PLC_PROG) && (32'(prg) < 32'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PLC_IDLE;
      tmr         <= '0;
      prg         <= '0;
      locked_page <= '0;
    end else begin
      unique case (state)
        PLC_IDLE: begin
          if (stb) begin
            locked_page <= stb_page;
            tmr         <= '0;
            state       <= PLC_LOAD;
          end
        end
        PLC_LOAD: begin
          if (page_hit) begin
            tmr <= '0;
          end else if (tmr == TMO_W'(LOAD_TIMEOUT - 1)) begin
            prg   <= '0;
            state <= PLC_PROG;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PLC_PROG: begin
          if (prg_last) begin
            prg   <= '0;
            state <= PLC_IDLE;
          end else begin
            prg <= prg + 1'b1;
          end
        end
        default: state <= PLC_IDLE;
      endcase
    end
  end

  assign buf_we    = (stb && (state == PLC_IDLE)) || page_hit;
  assign buf_widx  = stb_ofs;
  assign buf_clr   = (state == PLC_PROG) && prg_last;
  assign buf_ridx  = prg[PAGE_OFS_W-1:0];
  assign ram_we    = in_copy && valid_mask[buf_ridx];
  assign ram_waddr = {locked_page, buf_ridx};
  assign ram_wdata = buf_rdata;
  assign loading   = (state == PLC_LOAD);
  assign busy      = (state == PLC_PROG);
endmodule

// File: rtl/plc_array.sv
// Storage array: one write port, one registered read port, cleared on reset.
module plc_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int PAGE_OFS_W   = 7,
  parameter int MIN_LOW      = 2,
  parameter int LOAD_TIMEOUT = 15000,
  parameter int PROG_CYCLES  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int PAGE_W     = ADDR_W - PAGE_OFS_W;
  localparam int PAGE_BYTES = 1 << PAGE_OFS_W;

  logic                  stb;
  logic [ADDR_W-1:0]     stb_addr;
  logic [DATA_W-1:0]     stb_data;
  logic [PAGE_W-1:0]     stb_page;
  logic                  buf_we;
  logic [PAGE_OFS_W-1:0] buf_widx;
  logic                  buf_clr;
  logic [PAGE_OFS_W-1:0] buf_ridx;
  logic [DATA_W-1:0]     buf_rdata;
  logic [PAGE_BYTES-1:0] valid_mask;
  logic                  ram_we;
  logic [ADDR_W-1:0]     ram_waddr;
  logic [DATA_W-1:0]     ram_wdata;
  logic [PAGE_W-1:0]     locked_page;
  logic                  loading;

  assign stb_page = stb_addr[ADDR_W-1:PAGE_OFS_W];

  plc_strobe_qual #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MIN_LOW(MIN_LOW)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .wdata   (wdata),
    .stb     (stb),
    .stb_addr(stb_addr),
    .stb_data(stb_data)
  );

  plc_page_buf #(
    .DATA_W    (DATA_W),
    .PAGE_OFS_W(PAGE_OFS_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (buf_we),
    .widx      (buf_widx),
    .wdata     (stb_data),
    .clr       (buf_clr),
    .ridx      (buf_ridx),
    .rdata     (buf_rdata),
    .valid_mask(valid_mask)
  );

  plc_load_seq #(
    .PAGE_W      (PAGE_W),
    .PAGE_OFS_W  (PAGE_OFS_W),
    .DATA_W      (DATA_W),
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .stb_page   (stb_page),
    .stb_ofs    (stb_addr[PAGE_OFS_W-1:0]),
    .valid_mask (valid_mask),
    .buf_rdata  (buf_rdata),
    .buf_we     (buf_we),
    .buf_widx   (buf_widx),
    .buf_clr    (buf_clr),
    .buf_ridx   (buf_ridx),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .locked_page(locked_page),
    .loading    (loading),
    .busy       (busy)
  );

  plc_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/plc_checks.sv
module plc_checks #(
  parameter int PAGE_W      = 3,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 1000000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  loading,
  input logic                  stb,
  input logic                  buf_we,
  input logic                  ram_we,
  input logic [PAGE_W-1:0]     stb_page,
  input logic [PAGE_W-1:0]     locked_page,
  input logic [PAGE_BYTES-1:0] valid_mask
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 32'd1;
    else busy_run <= '0;
  end

  // R2: a qualified strobe yields a single-cycle byte event
  p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R4: bytes stored mid-load always belong to the locked page
  p_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && loading) |-> (stb_page == locked_page));

  // R6: programming never outlasts its cycle budget
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 32'(PROG_CYCLES)));

  // R6: programming ends exactly at its cycle budget
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(PROG_CYCLES)));

  // R7: the array is only written inside the programming phase
  p_copy_in_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  // R8: no byte is loaded while programming
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);

  // R9: the mask is empty once programming completes
  p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (valid_mask == '0));
endmodule

bind page_load_ctrl plc_checks #(
  .PAGE_W     (PAGE_W),
  .PAGE_BYTES (PAGE_BYTES),
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .loading    (loading),
  .stb        (stb),
  .buf_we     (buf_we),
  .ram_we     (ram_we),
  .stb_page   (stb_page),
  .locked_page(locked_page),
  .valid_mask (valid_mask)
);

// File: tb/sim_page_load_ctrl.sv
`timescale 1ns/1ps
module sim_page_load_ctrl;
  localparam int AW    = 9;
  localparam int DW    = 8;
  localparam int OFS   = 7;
  localparam int MINL  = 3;
  localparam int L     = 40;
  localparam int P     = 300;
  localparam int DEPTH = 1 << AW;
  localparam int PB    = 1 << OFS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] pend  [PB];
  bit         pmask [PB];
  int         ppage = 0;
  bit         lmode = 0;

  always #5 clk = ~clk;

  page_load_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_OFS_W(OFS), .MIN_LOW(MINL),
    .LOAD_TIMEOUT(L), .PROG_CYCLES(P)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: write-strobe controlled, mode 1: chip-select controlled
  task automatic strobe(input int a, input int d, input int lowc, input int mode);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); oe_n = 1'b1;
    if (mode == 0) begin
      ce_n = 1'b0; we_n = 1'b0;
      repeat (lowc) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
    end else begin
      we_n = 1'b0;
      @(negedge clk);
      ce_n = 1'b0;
      repeat (lowc) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      we_n = 1'b1;
    end
    @(negedge clk);
  endtask

  // accepted-byte model: page lock, discard of foreign pages
  task automatic load(input int a, input int d, input int mode);
    strobe(a, d, 4, mode);
    if (!lmode) begin
      lmode = 1;
      ppage = a >> OFS;
    end
    if ((a >> OFS) == ppage) begin
      pend[a % PB]  = 8'(d);
      pmask[a % PB] = 1;
    end
  endtask

  task automatic commit();
    for (int i = 0; i < PB; i++) begin
      if (pmask[i]) model[ppage * PB + i] = pend[i];
      pmask[i] = 0;
    end
    lmode = 0;
  endtask

  task automatic finish_prog(input bit do_len);
    int n;
    n = 0;
    while (!busy && n < 2 * L + 50) begin
      @(negedge clk);
      n++;
    end
    chk(busy, "R5 programming started", busy, 1);
    n = 0;
    while (busy && n < P + 10) begin
      @(negedge clk);
      n++;
    end
    if (do_len) chk(n == P, "R6 busy length", n, P);
    commit();
  endtask

  task automatic readback(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      chk(rd_data == model[a], tag, int'(rd_data), int'(model[a]));
    end
  endtask

  task automatic idle_check(input int cyc, input string tag);
    bit seen;
    seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    for (int i = 0; i < PB; i++) begin pend[i] = 8'h00; pmask[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    readback("R1 cleared array / R10 read port");

    // main sweep: every page, stride and order vary per round (R7)
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < PB; k++) begin
        int idx;
        idx = (r % 2 == 1) ? (PB - 1 - k) : k;
        if (idx % (r + 2) == 0)
          load(r * PB + idx, (idx * 13 + r * 37 + 5) % 256, r % 2);
      end
      load(r * PB, 8'hA5 ^ r, 0);            // R7 overwrite in same load
      repeat (L - 6) @(negedge clk);
      chk(!busy, "R5 window still open", busy, 0);
      finish_prog(1);
      readback("R7 sweep readback");
    end

    // R2: short overlap and output-enable-low strobes load nothing
    strobe(1 * PB + 3, 8'h5A, MINL - 1, 0);
    strobe(1 * PB + 4, 8'h5B, MINL - 1, 1);
    @(negedge clk); oe_n = 1'b0;
    addr = AW'(1 * PB + 5); wdata = 8'h5C; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle_check(L + 20, "R2 rejected strobes start no load");
    for (int a = 3; a < 6; a++) begin
      @(negedge clk); rd_addr = AW'(PB + a);
      @(negedge clk);
      chk(rd_data == model[PB + a], "R2 rejected byte unchanged", rd_data, model[PB + a]);
    end

    // R3: first address, last data
    @(negedge clk);
    addr = AW'(2 * PB + 20); wdata = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = AW'(2 * PB + 21); wdata = 8'h22;
    @(negedge clk); wdata = 8'h33;
    @(negedge clk); wdata = 8'h44;
    @(negedge clk); ce_n = 1'b1;
    wdata = 8'h99;
    @(negedge clk); we_n = 1'b1;
    lmode = 1; ppage = 2; pend[20] = 8'h44; pmask[20] = 1;
    finish_prog(1);
    for (int a = 20; a < 22; a++) begin
      @(negedge clk); rd_addr = AW'(2 * PB + a);
      @(negedge clk);
      chk(rd_data == model[2 * PB + a], "R3 capture edges", rd_data, model[2 * PB + a]);
    end

    // R4: foreign-page byte late in the window does not extend it
    load(2 * PB + 10, 8'hC3, 0);
    repeat (L - 14) @(negedge clk);
    load(3 * PB + 11, 8'h3C, 0);
    repeat (12) @(negedge clk);
    chk(busy, "R4 timer not restarted by foreign page", busy, 1);
    finish_prog(0);
    readback("R4 foreign page byte discarded");

    // R8: strobe during programming is ignored
    load(0 * PB + 1, 8'h77, 0);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    strobe(0 * PB + 2, 8'h99, 4, 0);
    while (busy) @(negedge clk);
    commit();
    idle_check(L + 20, "R8 no load after busy strobe");
    readback("R8 array after busy strobe");

    // R9: stale mask must not reprogram earlier bytes on a new page
    load(0 * PB + 0, 8'h0B, 0);
    load(0 * PB + 1, 8'h16, 1);
    finish_prog(1);
    load(1 * PB + 5, 8'h21, 0);
    finish_prog(1);
    readback("R9 mask cleared between loads");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule